// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block is the part of a processor bus controller that runs the interrupt acknowledge handshake toward two cascaded interrupt controllers, one master and one slave. When a request arrives while the sequencer is idle, it runs two acknowledge bus cycles. Each cycle has one status state and then one or more command states. The bus stays locked from the status state of the first cycle to the end of the second cycle, and a fixed number of idle states separates the two cycles.

During the first acknowledge pulse the master controller picks the slave that will answer. The master cascade enable is high during the status and command states of both cycles, so the cascade address can reach the slave over the local address bus. When ready is sampled in the last command state of the second cycle, a one-cycle strobe marks the point where the 8-bit vector on the low data lines is to be captured. Requests that arrive while a sequence is running are not stored. The number of idle states between the cycles is the parameter `IDLE_GAP`, default 3.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, status_o, cmd_o, mce_o and vec_strobe_o are 0, and inta_no and lock_no are 1. A high rdy_i on its own changes none of these outputs.
- R2: If irq_req_i is high at a clock edge while the sequencer is idle, the next cycle is the status state of the first acknowledge cycle: status_o=1, lock_no=0, mce_o=1, inta_no=1.
- R3: A status state is always followed by command states (cmd_o=1, inta_no=0, mce_o=1). Command states repeat while rdy_i is sampled low and end at the edge where rdy_i is sampled high.
- R4: After the first cycle's last command state there are exactly IDLE_GAP idle states with status_o=0, cmd_o=0, inta_no=1, mce_o=0 and lock_no=0.
- R5: The second acknowledge cycle starts right after the idle states, with one status state followed by command states, with the same signalling as R2 and R3.
- R6: vec_strobe_o is 1 only in the last command state of the second cycle, in the cycle where rdy_i is high. It is never 1 during the first cycle.
- R7: lock_no stays 0 from the first status state through the second cycle's last command state, and returns to 1 in the next cycle, which is idle.
- R8: mce_o is 1 in every status and command state of both cycles, and 0 in the idle states between them and outside a sequence.
- R9: A request that is high while a sequence runs does not alter it. If the request is still high when the sequence ends, the sequencer spends exactly one idle cycle and then starts a new sequence.
- R10: Every sequence produces exactly two falling edges on inta_no.
- R11: status_o and cmd_o are never 1 together, and inta_no is 0 only while cmd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request, level |
| rdy_i | input | 1 | Ready for the current bus cycle, sampled in command states |
| status_o | output | 1 | Status state of an acknowledge cycle |
| cmd_o | output | 1 | Command state of an acknowledge cycle |
| inta_no | output | 1 | Acknowledge strobe, active low |
| lock_no | output | 1 | Bus lock, active low |
| mce_o | output | 1 | Master cascade enable |
| vec_strobe_o | output | 1 | Vector capture strobe, one cycle |

## Verification
The bench builds two instances of the sequencer: the default with three idle states and a second with one idle state. The one-state gap checks the counter at its smallest terminal count. For each instance, every combination of zero to three ready wait states in the first and in the second cycle is run, and the full output vector is compared in every cycle against a timeline computed from the wait counts and the gap. Further runs hold the request high across a whole sequence to confirm that the request is ignored and that the sequencer restarts after one idle cycle.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TS1  = 3'd1,
    PH_TC1  = 3'd2,
    PH_GAP  = 3'd3,
    PH_TS2  = 3'd4,
    PH_TC2  = 3'd5
  } ack_phase_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_ack_gap_cnt.sv
module irq_ack_gap_cnt #(
  parameter int unsigned IDLE_GAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = irq_ack_pkg::cnt_width(IDLE_GAP);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_GAP - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rdy_i,
  input  logic       gap_done_i,
  output ack_phase_e phase_o,
  output logic       gap_run_o
);
  ack_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_i)      phase_d = PH_TS1;
      PH_TS1:                  phase_d = PH_TC1;
      PH_TC1:  if (rdy_i)      phase_d = PH_GAP;
      PH_GAP:  if (gap_done_i) phase_d = PH_TS2;
      PH_TS2:                  phase_d = PH_TC2;
      PH_TC2:  if (rdy_i)      phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o   = phase_q;
  assign gap_run_o = (phase_q == PH_GAP);

  // requests are only taken from idle
  assert_req_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> (phase_q != PH_TS1));
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
  import irq_ack_pkg::*;
(
  input  ack_phase_e phase_i,
  input  logic       rdy_i,
  output logic       status_o,
  output logic       cmd_o,
  output logic       inta_no,
  output logic       lock_no,
  output logic       mce_o,
  output logic       vec_strobe_o
);
  always_comb begin
    status_o     = (phase_i == PH_TS1) || (phase_i == PH_TS2);
    cmd_o        = (phase_i == PH_TC1) || (phase_i == PH_TC2);
    inta_no      = !cmd_o;
    lock_no      = (phase_i == PH_IDLE);
    mce_o        = status_o || cmd_o;
    vec_strobe_o = (phase_i == PH_TC2) && rdy_i;
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int unsigned IDLE_GAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  input  logic rdy_i,
  output logic status_o,
  output logic cmd_o,
  output logic inta_no,
  output logic lock_no,
  output logic mce_o,
  output logic vec_strobe_o
);
  localparam int unsigned CHK_W = cnt_width(IDLE_GAP + 2);

  ack_phase_e phase;
  logic       gap_run, gap_done;

  irq_ack_gap_cnt #(.IDLE_GAP(IDLE_GAP)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gap_run),
    .done_o (gap_done)
  );

  irq_ack_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (irq_req_i),
    .rdy_i      (rdy_i),
    .gap_done_i (gap_done),
    .phase_o    (phase),
    .gap_run_o  (gap_run)
  );

  irq_ack_decode u_dec (
    .phase_i      (phase),
    .rdy_i        (rdy_i),
    .status_o     (status_o),
    .cmd_o        (cmd_o),
    .inta_no      (inta_no),
    .lock_no      (lock_no),
    .mce_o        (mce_o),
    .vec_strobe_o (vec_strobe_o)
  );

  // checker: counts idle states seen since the first cycle completed
  logic [CHK_W-1:0] gap_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_seen_q <= '0;
    else if (phase == PH_TS1)          gap_seen_q <= '0;
    else if (!status_o && !cmd_o && !lock_no) gap_seen_q <= gap_seen_q + 1'b1;
  end

  assert_req_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_no && irq_req_i) |=> (status_o && !lock_no && mce_o));
  assert_ts_to_tc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |=> (cmd_o && !inta_no));
  assert_tc_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o && !rdy_i) |=> cmd_o);
  assert_gap_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TS2) |-> (gap_seen_q == CHK_W'(IDLE_GAP)));
  assert_strobe_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_strobe_o |-> (cmd_o && rdy_i && gap_seen_q == CHK_W'(IDLE_GAP)));
  assert_lock_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_no) |-> $past(vec_strobe_o));
  assert_mce_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_o |-> (!lock_no && (status_o || cmd_o)));
  assert_phase_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o && cmd_o) && (inta_no || cmd_o));
endmodule

// File: tb/irq_ack_seq_test.sv
module irq_ack_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, rdy_a = 1'b0, req_b = 1'b0, rdy_b = 1'b0;
  logic [5:0] out_a, out_b;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  // vector: {status, cmd, inta_n, lock_n, mce, strobe}
  localparam logic [5:0] V_IDLE = 6'b001100;
  localparam logic [5:0] V_TS   = 6'b101010;
  localparam logic [5:0] V_TC   = 6'b010010;
  localparam logic [5:0] V_GAP  = 6'b001000;

  irq_ack_seq #(.IDLE_GAP(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req_a), .rdy_i(rdy_a),
    .status_o(out_a[5]), .cmd_o(out_a[4]), .inta_no(out_a[3]),
    .lock_no(out_a[2]), .mce_o(out_a[1]), .vec_strobe_o(out_a[0]));

  irq_ack_seq #(.IDLE_GAP(1)) uut_short (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req_b), .rdy_i(rdy_b),
    .status_o(out_b[5]), .cmd_o(out_b[4]), .inta_no(out_b[3]),
    .lock_no(out_b[2]), .mce_o(out_b[1]), .vec_strobe_o(out_b[0]));

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] cur_out(input bit sel);
    return sel ? out_b : out_a;
  endfunction

  task automatic set_req(input bit sel, input logic v);
    if (sel) req_b = v; else req_a = v;
  endtask

  task automatic set_rdy(input bit sel, input logic v);
    if (sel) rdy_b = v; else rdy_a = v;
  endtask

  // Call one cycle before the intended start, at a sample point of an idle cycle.
  task automatic run_seq(input bit sel, input int w1, input int w2, input bit hold);
    int g = sel ? 1 : 3;
    int last = 4 + w1 + g + w2;
    int falls = 0;
    logic prev_inta = 1'b1;
    string sfx = hold ? " R9" : "";
    set_req(sel, 1'b1);
    set_rdy(sel, 1'b0);
    for (int idx = 0; idx <= last; idx++) begin
      logic [5:0] exp;
      logic [5:0] act;
      string tag;
      @(negedge clk);
      if (!hold && idx == 0) set_req(sel, 1'b0);
      set_rdy(sel, (idx == 1 + w1) || (idx == 3 + w1 + g + w2));
      #1;
      if (idx == 0) begin exp = V_TS; tag = "R2/R8"; end
      else if (idx <= 1 + w1) begin exp = V_TC; tag = "R3/R8"; end
      else if (idx <= 1 + w1 + g) begin exp = V_GAP; tag = "R4/R8"; end
      else if (idx == 2 + w1 + g) begin exp = V_TS; tag = "R5/R7"; end
      else if (idx < last) begin
        exp = V_TC;
        exp[0] = (idx == last - 1);
        tag = "R6/R5";
      end else begin exp = V_IDLE; tag = "R7/R1"; end
      act = cur_out(sel);
      chk($sformatf("%s%s inst=%0d w1=%0d w2=%0d idx=%0d", tag, sfx, sel, w1, w2, idx), act, exp);
      checks++;
      if ((act[5] && act[4]) || (!act[3] && !act[4])) begin
        fails++;
        $display("FAIL R11 idx=%0d: actual %b expected exclusive phases", idx, act);
      end
      if (prev_inta && !act[3]) falls++;
      prev_inta = act[3];
      if (idx == last) set_rdy(sel, 1'b0);
    end
    checks++;
    if (falls != 2) begin
      fails++;
      $display("FAIL R10 inst=%0d: actual %0d expected 2 inta falls", sel, falls);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset uut", out_a, V_IDLE);
    chk("R1 reset uut_short", out_b, V_IDLE);
    rst_n = 1'b1;
    // ready alone while idle must not start anything (R1, R6)
    rdy_a = 1'b1; rdy_b = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R1/R6 rdy idle uut", out_a, V_IDLE);
      chk("R1/R6 rdy idle uut_short", out_b, V_IDLE);
    end
    rdy_a = 1'b0; rdy_b = 1'b0;
    @(negedge clk); #1;
    for (int s = 0; s < 2; s++)
      for (int w1 = 0; w1 < 4; w1++)
        for (int w2 = 0; w2 < 4; w2++)
          run_seq(s[0], w1, w2, 1'b0);
    // held request: ignored mid-sequence, restart after one idle cycle (R9)
    for (int s = 0; s < 2; s++) begin
      run_seq(s[0], 1, 2, 1'b1);
      run_seq(s[0], 0, 0, 1'b1);
      run_seq(s[0], 2, 0, 1'b0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk("R9 idle after drop", cur_out(s[0]), V_IDLE);
      end
    end
    finish_run();
  end
endmodule